// File: doc/BRIEF.md
# Two-Channel Integration Window Controller

This block runs back-to-back integration cycles for a two-channel light converter. Each channel's integrator is represented by a pulse input. Over a window chosen by a 2-bit field, the block counts the pulses on each channel. A rate limiter admits at most one count every two clocks, so a window of N clocks can never hold more than N/2 counts.

When the window closes, both raw counts are captured together. The capture subtracts a fixed offset of two counts, floors the result at zero and clamps it to the result width. The captured values then pass through a second register stage into the result outputs, and a single-cycle done strobe marks each update. A new window starts on the very next clock with no gap.

Window lengths are multiples of a base unit. The defaults give 11, 81 and 322 units of 918 clocks. The last field code parks the block, and deasserting the enable does the same. Either way the two result registers keep the last values they received.

Top module: `lux_cycle_ctrl`

## Requirements
- R1: With the field at 00, 01 or 10, a window lasts UNIT times 11, 81 or 322 clocks respectively, where UNIT is a parameter (default 918).
- R2: A pulse is counted only if no pulse was counted in the previous clock of the same window. A pulse in a blocked clock is lost. The limiter starts clear at every window start.
- R3: Each result equals the window's counted pulses minus 2, and is 0 when the count is 2 or less.
- R4: Results saturate at 2^CNT_W − 1 (65535 by default).
- R5: Both results update on the same clock as a one-cycle done strobe. That clock is the second rising edge counted from the start of the window's last cycle. Between strobes the results hold.
- R6: A new window starts on the clock after the previous one ends, and the next done follows one window length later.
- R7: Field value 11 keeps the timer and counters at zero and produces no done. The results keep their values.
- R8: Enable low clears the timer, the counters and the limiter but keeps the results. The first cycle with enable high is window cycle 0.
- R9: While reset is active, and after it, both results are 0 and done is 0 until the first transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable |
| itime | input | 2 | Window select: 00 short, 01 medium, 10 long, 11 idle |
| pulse_ch0 | input | 1 | Integrator pulse, channel 0 |
| pulse_ch1 | input | 1 | Integrator pulse, channel 1 |
| res_ch0 | output | CNT_W | Buffered result, channel 0 |
| res_ch1 | output | CNT_W | Buffered result, channel 1 |
| done | output | 1 | One-cycle strobe on each result update |

## Verification
The bench builds the block with UNIT = 8 and CNT_W = 10. This shrinks the windows to 88, 648 and 2576 clocks, so every field code, including the longest window, fits many times into the run. With 10 result bits, the long window with a pulse on every clock yields 1286 after the offset, which lies above the 1023 ceiling. The saturation path is therefore reached, which the default width would only reach after more than 131000 clocks. The windows are short enough for exact hand-computed counts under periodic pulse patterns, including offset flooring and back-to-back restarts.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
  typedef enum logic [1:0] {
    FLD_SHORT = 2'b00,
    FLD_MID   = 2'b01,
    FLD_LONG  = 2'b10,
    FLD_IDLE  = 2'b11
  } itime_e;

  localparam int NCH = 2;
endpackage

// File: rtl/lcc_window_timer.sv
module lcc_window_timer #(
  parameter int UNIT = 918,
  parameter int M0   = 11,
  parameter int M1   = 81,
  parameter int M2   = 322
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] fld,
  output logic       win_last
);
  import lcc_pkg::*;

  localparam int L0 = UNIT * M0;
  localparam int L1 = UNIT * M1;
  localparam int L2 = UNIT * M2;
  localparam int TW = $clog2(L2 + 1);

  logic [TW-1:0] t_q, t_d, len_m1;

  always_comb begin
    unique case (itime_e'(fld))
      FLD_SHORT: len_m1 = TW'(L0 - 1);
      FLD_MID:   len_m1 = TW'(L1 - 1);
      default:   len_m1 = TW'(L2 - 1);
    endcase
  end

  // R1: window closes when the timer reaches length-1
  always_comb begin
    win_last = run && (t_q >= len_m1);
    if (!run || win_last) t_d = '0;
    else                  t_d = t_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) t_q <= '0;
    else        t_q <= t_d;
  end
endmodule

// File: rtl/lcc_pulse_counter.sv
module lcc_pulse_counter #(
  parameter int RW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  input  logic          pulse,
  output logic          acc,
  output logic [RW-1:0] total
);
  logic [RW-1:0] cnt_q, cnt_d;
  logic          blk_q, blk_d;

  // R2: admit a pulse only if the previous clock admitted none
  always_comb begin
    acc = run && pulse && !blk_q;
    if (cnt_q == {RW{1'b1}}) total = cnt_q;
    else                     total = cnt_q + {{(RW-1){1'b0}}, acc};
    if (!run || clr) begin
      cnt_d = '0;
      blk_d = 1'b0;
    end else begin
      cnt_d = total;
      blk_d = acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      blk_q <= blk_d;
    end
  end
endmodule

// File: rtl/lcc_result_buffer.sv
module lcc_result_buffer #(
  parameter int CNT_W = 16,
  parameter int OFS   = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 load,
  input  logic [lcc_pkg::NCH-1:0][CNT_W:0]     raw,
  output logic [lcc_pkg::NCH-1:0][CNT_W-1:0]   res,
  output logic                                 done
);
  import lcc_pkg::*;

  localparam logic [CNT_W:0]   OFS_V = (CNT_W+1)'(OFS);
  localparam logic [CNT_W:0]   MAX_W = {1'b0, {CNT_W{1'b1}}};

  logic [NCH-1:0][CNT_W-1:0] adj, stg_q, stg_d, res_q, res_d;
  logic                      pend_q, done_q;

  for (genvar c = 0; c < NCH; c++) begin : g_adj
    logic [CNT_W:0] diff;
    // R3 offset with floor, R4 clamp
    always_comb begin
      diff = raw[c] - OFS_V;
      if (raw[c] <= OFS_V)   adj[c] = '0;
      else if (diff > MAX_W) adj[c] = {CNT_W{1'b1}};
      else                   adj[c] = diff[CNT_W-1:0];
    end
  end

  // R5: stage captures both channels at once, output stage copies them together
  always_comb begin
    stg_d = load   ? adj   : stg_q;
    res_d = pend_q ? stg_q : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      res_q  <= '0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      stg_q  <= stg_d;
      res_q  <= res_d;
      pend_q <= load;
      done_q <= pend_q;
    end
  end

  assign res  = res_q;
  assign done = done_q;
endmodule

// File: rtl/lux_cycle_ctrl.sv
module lux_cycle_ctrl #(
  parameter int UNIT  = 918,
  parameter int M0    = 11,
  parameter int M1    = 81,
  parameter int M2    = 322,
  parameter int CNT_W = 16,
  parameter int OFS   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       itime,
  input  logic             pulse_ch0,
  input  logic             pulse_ch1,
  output logic [CNT_W-1:0] res_ch0,
  output logic [CNT_W-1:0] res_ch1,
  output logic             done
);
  import lcc_pkg::*;

  localparam int RW = CNT_W + 1;

  logic [1:0]                rs_q;
  logic                      rst_i_n;
  logic                      run, win_last;
  logic [NCH-1:0]            pulse_v, acc_v;
  logic [NCH-1:0][RW-1:0]    raw_v;
  logic [NCH-1:0][CNT_W-1:0] res_v;

  // reset asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  // R7, R8: run only with enable high and a real window code
  assign run     = en && (itime_e'(itime) != FLD_IDLE);
  assign pulse_v = {pulse_ch1, pulse_ch0};

  lcc_window_timer #(.UNIT(UNIT), .M0(M0), .M1(M1), .M2(M2)) i_tmr (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .run      (run),
    .fld      (itime),
    .win_last (win_last)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    lcc_pulse_counter #(.RW(RW)) i_cnt (
      .clk   (clk),
      .rst_n (rst_i_n),
      .run   (run),
      .clr   (win_last),
      .pulse (pulse_v[c]),
      .acc   (acc_v[c]),
      .total (raw_v[c])
    );
  end

  lcc_result_buffer #(.CNT_W(CNT_W), .OFS(OFS)) i_buf (
    .clk   (clk),
    .rst_n (rst_i_n),
    .load  (win_last),
    .raw   (raw_v),
    .res   (res_v),
    .done  (done)
  );

  assign res_ch0 = res_v[0];
  assign res_ch1 = res_v[1];
endmodule

// File: rtl/lcc_checker.sv
module lcc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             win_last,
  input logic [1:0]       acc,
  input logic             done,
  input logic [CNT_W-1:0] res_ch0,
  input logic [CNT_W-1:0] res_ch1
);
  // R5: strobe lasts one clock
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: results move only with the strobe
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_ch0) && $stable(res_ch1)));

  // R2: no two admitted counts in consecutive clocks inside a window
  p_limit0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc[0] && !win_last) |=> !acc[0]);
  p_limit1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc[1] && !win_last) |=> !acc[1]);

  // R7 and R8: two idle clocks in a row leave no strobe
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !$past(run)) |=> !done);
endmodule

bind lux_cycle_ctrl lcc_checker #(.CNT_W(CNT_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .win_last (win_last),
  .acc      (acc_v),
  .done     (done),
  .res_ch0  (res_ch0),
  .res_ch1  (res_ch1)
);

// File: tb/test_lux_cycle_ctrl.sv
module test_lux_cycle_ctrl;
  localparam int UNIT  = 8;
  localparam int CNT_W = 10;

  logic             clk = 1'b0;
  logic             rst_n, en, p0, p1;
  logic [1:0]       itime;
  logic [CNT_W-1:0] r0, r1;
  logic             done;
  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  lux_cycle_ctrl #(.UNIT(UNIT), .CNT_W(CNT_W)) i_lux_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .itime(itime),
    .pulse_ch0(p0), .pulse_ch1(p1),
    .res_ch0(r0), .res_ch1(r1), .done(done)
  );

  typedef struct packed {
    logic [1:0] fld;
    int per0;
    int per1;
    int e0;
    int e1;
  } vec_t;

  // window lengths 88 / 648 / 2576; period 0 = no pulses
  localparam vec_t VEC [7] = '{
    '{2'b00, 1,  1,  42,   42},   // R2 every other pulse lost
    '{2'b00, 3,  4,  28,   20},
    '{2'b00, 2,  0,  42,   0},    // R3 floor on empty channel
    '{2'b00, 87, 30, 0,    1},    // R3 count 2 -> 0, count 3 -> 1
    '{2'b01, 1,  5,  322,  128},  // R1 medium window
    '{2'b10, 1,  3,  1023, 857},  // R4 clamp on ch0
    '{2'b10, 4,  7,  642,  366}   // R1 long window
  };

  function automatic int win_len(input logic [1:0] f);
    return (f == 2'b00) ? UNIT*11 : (f == 2'b01) ? UNIT*81 : UNIT*322;
  endfunction

  function automatic logic hit(input int k, input int per);
    return (per == 0) ? 1'b0 : ((k % per) == 0);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // starts and ends at a negedge; returns after the strobe cycle
  task automatic run_window(input logic [1:0] f, input int q0, input int q1,
                            input int e0, input int e1, input string tag);
    int len;
    len   = win_len(f);
    itime = f;
    en    = 1'b1;
    for (int k = 0; k < len; k++) begin
      p0 = hit(k, q0);
      p1 = hit(k, q1);
      @(negedge clk);
      if (done) chk({tag, " R5 early done"}, 1, 0);
    end
    p0 = 1'b0; p1 = 1'b0; en = 1'b0;
    @(negedge clk);
    chk({tag, " R5 done"}, int'(done), 1);
    chk({tag, " R3 ch0"}, int'(r0), e0);
    chk({tag, " R3 ch1"}, int'(r1), e1);
    @(negedge clk);
    chk({tag, " R5 strobe width"}, int'(done), 0);
    chk({tag, " R8 results kept"}, int'(r0), e0);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int first, second, nd, keep0, keep1, len;
    rst_n = 1'b0; en = 1'b0; itime = 2'b00; p0 = 1'b0; p1 = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 reset ch0", int'(r0), 0);
    chk("R9 reset ch1", int'(r1), 0);
    chk("R9 reset done", int'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 after release", int'(r0 | r1), 0);

    for (int i = 0; i < 7; i++)
      run_window(VEC[i].fld, VEC[i].per0, VEC[i].per1, VEC[i].e0, VEC[i].e1, "vec");

    // R8: pulses while disabled make no strobe and keep results
    nd = 0;
    for (int k = 0; k < 200; k++) begin
      p0 = 1'b1; p1 = 1'b1;
      @(negedge clk);
      nd += int'(done);
    end
    chk("R8 disabled no done", nd, 0);
    chk("R8 disabled ch1 kept", int'(r1), 366);

    // R8: partial window is cleared by enable low
    en = 1'b1; itime = 2'b00;
    repeat (40) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    run_window(2'b00, 1, 3, 42, 28, "R8 restart clean");

    // R7: idle code
    keep0 = int'(r0); keep1 = int'(r1);
    en = 1'b1; itime = 2'b11; p0 = 1'b1; p1 = 1'b1; nd = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      nd += int'(done);
    end
    chk("R7 idle no done", nd, 0);
    chk("R7 idle ch0 kept", int'(r0), keep0);
    chk("R7 idle ch1 kept", int'(r1), keep1);
    en = 1'b0;
    @(negedge clk);
    run_window(2'b00, 2, 4, 42, 20, "R7 after idle");

    // R6: back-to-back windows
    len = win_len(2'b00);
    first = -1; second = -1; nd = 0;
    en = 1'b1; itime = 2'b00; p0 = 1'b1; p1 = 1'b0;
    for (int e = 1; e <= 2*len + 1; e++) begin
      @(negedge clk);
      if (done) begin
        nd++;
        if (first < 0) first = e; else second = e;
        chk("R6 value", int'(r0), 42);
      end
    end
    en = 1'b0; p0 = 1'b0;
    chk("R6 first done edge", first, len + 1);
    chk("R6 second done edge", second, 2*len + 1);
    chk("R6 done count", nd, 2);
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule